// File: doc/BRIEF.md
# DRAM Controller with CAS-before-RAS Refresh

This block connects a simple processor-side memory request channel to a bank of asynchronous DRAM devices with byte-wide data and a shared multiplexed address bus. Each request carries a full byte address, a read/write flag and write data. The controller splits the address into a device select, a row and a column. It then runs one complete access: the row goes out on the address bus and the selected device's row strobe falls, the column goes out and the column strobe falls, and the device is precharged at the end. Read data goes back with a single-cycle response.

Refresh runs without any help from the requester. An interval counter marks a refresh as due once every `REFRESH_PERIOD` cycles. The controller serves that refresh by lowering the shared column strobe first and all row strobes after it, so no refresh row address is ever driven. A refresh that falls due during an access waits until that access has precharged. It then goes ahead of any request that is waiting.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields steady while `req_valid` is high and `req_ready` is low. `req_ready` is high only when the controller is idle and no refresh is due. The response side cannot push back: `rsp_valid` is a one-cycle pulse, and `rsp_rdata` must be taken in that cycle.

Top module: `dramc_top`

## Requirements
- R1: While reset is held and after it is released, with no request: every row strobe, the column strobe, WE and OE are high (inactive), `dram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The address is split as device = `req_addr[20:19]`, row = `req_addr[18:9]`, column = `req_addr[8:0]`. During an access only `dram_ras_n[device]` goes low. No two row strobes are ever low together except during refresh.
- R3: The row is on `dram_ma` for at least one cycle before the row strobe falls, and it is unchanged in the cycle the strobe falls. The column (zero-extended to 10 bits) is on `dram_ma` for at least one cycle before the column strobe falls, and it is unchanged in that cycle.
- R4: On a read, OE is low only while the column strobe is low, with WE high and `dram_dq_oe` 0. `rsp_rdata` equals the device data present in the last cycle of the column strobe.
- R5: On a write, WE is low from at least one cycle before the column strobe falls until the strobe rises. `dram_dq_oe` is 1 only while WE is low, and `dram_dq_out` then carries the request's write data.
- R6: With default timing, `rsp_valid` rises exactly 6 cycles after the accepting edge, in the cycle right after the column strobe rises. It lasts one cycle, and exactly one response comes per accepted request.
- R7: A refresh lowers the column strobe while all row strobes are high. At least `CBR_LEAD` cycles later all row strobes fall together. WE and OE stay high and `dram_ma` stays 0 throughout.
- R8: While no access is in progress, successive refreshes begin exactly `REFRESH_PERIOD` cycles apart.
- R9: A refresh that falls due during an access starts only after that access has precharged. `req_ready` stays low while it is due, and a waiting request is accepted only after the refresh precharge.
- R10: Once the row strobes rise, at least `PRE_CYC` cycles pass with all of them high before any row strobe falls again.
- R11: `req_ready` is low from the accepting edge until the access precharge has finished. With default timing it is high again 8 cycles after acceptance if no refresh is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address (device, row, column) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` after a read |
| dram_ras_n | output | 4 | Row strobes, one per device, active low |
| dram_cas_n | output | 1 | Shared column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_ma | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven toward the devices |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data returned by the devices |

## Verification
If the sequencer loses its place, it shows up at the strobes within a cycle or two. Possible symptoms are a second row strobe falling, the column strobe falling before the address has been set up, OE opening outside the column phase, or a response landing off its fixed six-cycle slot. A wrong device select or a misplaced address field shows up at the very next row or column strobe edge, as a mismatch against the decode computed from the request. A refresh timer that drifts or stalls shows up within one refresh period, as an idle interval that differs from `REFRESH_PERIOD` or a refresh that overlaps an access.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_PRE,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_CBR_PRE
  } dram_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
  parameter int PERIOD = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic pending
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= CW'(PERIOD - 1);
      pending  <= 1'b0;
    end else begin
      if (grant) pending <= 1'b0;
      if (tick_cnt == '0) begin
        tick_cnt <= CW'(PERIOD - 1);
        pending  <= 1'b1;
      end else begin
        tick_cnt <= tick_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dramc_addr_map.sv
module dramc_addr_map #(
  parameter int DEV_N = 4,
  parameter int ROW_W = 10,
  parameter int COL_W = 9,
  localparam int SEL_W  = $clog2(DEV_N),
  localparam int ADDR_W = SEL_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DEV_N-1:0]  dev_oh,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  logic [SEL_W-1:0] dev_idx;

  assign dev_idx = addr[ADDR_W-1 -: SEL_W];
  assign row     = addr[COL_W +: ROW_W];
  assign col     = addr[COL_W-1:0];

  for (genvar g = 0; g < DEV_N; g++) begin : g_dec
    assign dev_oh[g] = (dev_idx == SEL_W'(g));
  end
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int DEV_N      = 4,
  parameter int ROW_W      = 10,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 8,
  parameter int RAS_TO_COL = 2,
  parameter int COL_SETUP  = 1,
  parameter int CAS_CYC    = 2,
  parameter int PRE_CYC    = 2,
  parameter int CBR_LEAD   = 1,
  parameter int CBR_RAS    = 3,
  localparam int MA_W  = max2(ROW_W, COL_W),
  localparam int T_MAX = max2(max2(max2(RAS_TO_COL, COL_SETUP), max2(CAS_CYC, PRE_CYC)),
                              max2(CBR_LEAD, CBR_RAS)),
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_write,
  input  logic [DEV_N-1:0]  in_dev_oh,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              ref_pending,
  output logic              ref_grant,
  output logic              idle_ready,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DEV_N-1:0]  ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [MA_W-1:0]   ma,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  dram_st_e          state;
  logic [CNT_W-1:0]  wait_cnt;
  logic              lat_write;
  logic [DEV_N-1:0]  lat_dev;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_wdata;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  assign idle_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_grant  = (state == ST_IDLE) && ref_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wait_cnt  <= '0;
      lat_write <= 1'b0;
      lat_dev   <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wdata <= '0;
      rdata_q   <= '0;
      rsp_q     <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (state == ST_IDLE) begin
        if (ref_pending) begin
          state    <= ST_CBR_CAS;
          wait_cnt <= CNT_W'(CBR_LEAD - 1);
        end else if (start) begin
          state     <= ST_ROW;
          wait_cnt  <= '0;
          lat_write <= in_write;
          lat_dev   <= in_dev_oh;
          lat_row   <= in_row;
          lat_col   <= in_col;
          lat_wdata <= in_wdata;
        end
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else begin
        unique case (state)
          ST_ROW: begin
            state    <= ST_RAS;
            wait_cnt <= CNT_W'(RAS_TO_COL - 1);
          end
          ST_RAS: begin
            state    <= ST_COL;
            wait_cnt <= CNT_W'(COL_SETUP - 1);
          end
          ST_COL: begin
            state    <= ST_CAS;
            wait_cnt <= CNT_W'(CAS_CYC - 1);
          end
          ST_CAS: begin
            if (!lat_write) rdata_q <= dq_in;
            rsp_q    <= 1'b1;
            state    <= ST_PRE;
            wait_cnt <= CNT_W'(PRE_CYC - 1);
          end
          ST_CBR_CAS: begin
            state    <= ST_CBR_RAS;
            wait_cnt <= CNT_W'(CBR_RAS - 1);
          end
          ST_CBR_RAS: begin
            state    <= ST_CBR_PRE;
            wait_cnt <= CNT_W'(PRE_CYC - 1);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  logic in_row_phase, in_col_phase;
  assign in_row_phase = (state == ST_ROW) || (state == ST_RAS);
  assign in_col_phase = (state == ST_COL) || (state == ST_CAS);

  always_comb begin
    ras_n = '1;
    if ((state == ST_RAS) || in_col_phase) ras_n = ~lat_dev;
    else if (state == ST_CBR_RAS)          ras_n = '0;
  end

  always_comb begin
    ma = '0;
    if (in_row_phase)      ma = MA_W'(lat_row);
    else if (in_col_phase) ma = MA_W'(lat_col);
  end

  assign cas_n     = !((state == ST_CAS) || (state == ST_CBR_CAS) || (state == ST_CBR_RAS));
  assign we_n      = !(lat_write && in_col_phase);
  assign oe_n      = !(!lat_write && (state == ST_CAS));
  assign dq_oe     = lat_write && in_col_phase;
  assign dq_out    = lat_wdata;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/dramc_top.sv
module dramc_top
  import dramc_pkg::*;
#(
  parameter int DEV_N          = 4,
  parameter int ROW_W          = 10,
  parameter int COL_W          = 9,
  parameter int DATA_W         = 8,
  parameter int REFRESH_PERIOD = 1950,
  parameter int RAS_TO_COL     = 2,
  parameter int COL_SETUP      = 1,
  parameter int CAS_CYC        = 2,
  parameter int PRE_CYC        = 2,
  parameter int CBR_LEAD       = 1,
  parameter int CBR_RAS        = 3,
  localparam int ADDR_W = $clog2(DEV_N) + ROW_W + COL_W,
  localparam int MA_W   = max2(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DEV_N-1:0]  dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MA_W-1:0]   dram_ma,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  logic [DEV_N-1:0] dec_dev;
  logic [ROW_W-1:0] dec_row;
  logic [COL_W-1:0] dec_col;
  logic             ref_pending, ref_grant, start;

  assign start = req_valid && req_ready;

  dramc_addr_map #(.DEV_N(DEV_N), .ROW_W(ROW_W), .COL_W(COL_W)) u_map (
    .addr(req_addr), .dev_oh(dec_dev), .row(dec_row), .col(dec_col)
  );

  dramc_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_rtim (
    .clk(clk), .rst_n(rst_n), .grant(ref_grant), .pending(ref_pending)
  );

  dramc_seq #(
    .DEV_N(DEV_N), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .RAS_TO_COL(RAS_TO_COL), .COL_SETUP(COL_SETUP), .CAS_CYC(CAS_CYC),
    .PRE_CYC(PRE_CYC), .CBR_LEAD(CBR_LEAD), .CBR_RAS(CBR_RAS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .in_write(req_write),
    .in_dev_oh(dec_dev), .in_row(dec_row), .in_col(dec_col), .in_wdata(req_wdata),
    .ref_pending(ref_pending), .ref_grant(ref_grant), .idle_ready(req_ready),
    .dq_in(dram_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .ma(dram_ma), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe)
  );
endmodule

// File: rtl/dramc_checker.sv
module dramc_checker #(
  parameter int DEV_N   = 4,
  parameter int MA_W    = 10,
  parameter int PRE_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [DEV_N-1:0] ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [MA_W-1:0]  ma,
  input logic             dq_oe
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= PRE_CYC;
    else if (&ras_n)   hi_cnt <= (hi_cnt >= PRE_CYC) ? PRE_CYC : hi_cnt + 1;
    else               hi_cnt <= 0;
  end

  p_ras_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ras_n) |-> (($countones(~ras_n) == 1) || (ras_n == '0)));

  p_row_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(ras_n)) && !(&ras_n) && cas_n) |-> (ma == $past(ma)));

  p_col_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !(&ras_n)) |-> (ma == $past(ma)));

  p_oe_in_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cas_n && we_n && !dq_oe));

  p_we_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));

  p_dq_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ack_after_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!cas_n) && cas_n));

  p_cbr_all_rows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(ras_n)) && !(&ras_n) && !$past(cas_n)) |-> (ras_n == '0));

  p_cbr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && (&ras_n)) |-> (we_n && oe_n && (ma == '0)));

  p_precharge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(ras_n)) && !(&ras_n)) |-> (hi_cnt >= PRE_CYC));

  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ras_n) || !cas_n) |-> !req_ready);
endmodule

bind dramc_top dramc_checker #(.DEV_N(DEV_N), .MA_W(MA_W), .PRE_CYC(PRE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .ma(dram_ma), .dq_oe(dram_dq_oe)
);

// File: tb/dramc_top_test.sv
`timescale 1ns/1ps
module dramc_top_test;
  localparam int DEV_N = 4, ROW_W = 10, COL_W = 9, DATA_W = 8;
  localparam int P = 64;
  localparam int RAS_TO_COL = 2, COL_SETUP = 1, CAS_CYC = 2, PRE_CYC = 2;
  localparam int CBR_LEAD = 1, CBR_RAS = 3;
  localparam int ADDR_W = 2 + ROW_W + COL_W;
  localparam int MA_W = 10;
  localparam int RSP_LAT  = 1 + RAS_TO_COL + COL_SETUP + CAS_CYC;
  localparam int FREE_LAT = RSP_LAT + PRE_CYC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata, dram_dq_out;
  logic [DEV_N-1:0] dram_ras_n;
  logic dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [MA_W-1:0] dram_ma;
  logic [DATA_W-1:0] dram_dq_in;

  always #4 clk = ~clk;

  dramc_top #(.REFRESH_PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_ma(dram_ma), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // behavioural device model and strobe monitor
  logic [7:0] mem [int];
  logic [DATA_W-1:0] rd_q = 8'h00;
  assign dram_dq_in = rd_q;
  logic [DEV_N-1:0] ras_prev = '1;
  logic cas_prev = 1'b1, we_prev = 1'b1;
  logic [MA_W-1:0] ma_prev = '0;
  int hi_cnt = 99, cas_lo_cnt = 0, ref_cnt = 0, last_ref = 0, last_acc = 0, cur_dev = 0;
  logic [DEV_N-1:0] exp_dev_oh = '0;
  logic [ROW_W-1:0] exp_row = '0, cur_row = '0;
  logic [COL_W-1:0] exp_col = '0;
  logic [DATA_W-1:0] exp_wdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((&ras_prev) && !(&dram_ras_n)) begin
        if (!cas_prev) begin
          chk(dram_ras_n == '0, "R7 all rows", dram_ras_n, 0);
          chk(cas_lo_cnt >= CBR_LEAD, "R7 cas lead", cas_lo_cnt, CBR_LEAD);
          chk(dram_we_n && dram_oe_n && dram_ma == '0, "R7 quiet", {dram_we_n, dram_oe_n, dram_ma}, 12'hC00);
          ref_cnt++;
          last_ref = cyc;
        end else begin
          chk(dram_ras_n == ~exp_dev_oh, "R2 device", dram_ras_n, ~exp_dev_oh);
          chk(dram_ma == ma_prev && dram_ma == MA_W'(exp_row), "R3 row", dram_ma, exp_row);
          chk(hi_cnt >= PRE_CYC, "R10 precharge", hi_cnt, PRE_CYC);
          for (int i = 0; i < DEV_N; i++) if (!dram_ras_n[i]) cur_dev = i;
          cur_row = exp_row;
          last_acc = cyc;
        end
      end
      if (cas_prev && !dram_cas_n && !(&dram_ras_n)) begin
        chk(dram_ma == ma_prev && dram_ma == MA_W'(exp_col), "R3 col", dram_ma, exp_col);
        if (!dram_we_n) begin
          chk(!we_prev, "R5 we lead", we_prev, 0);
          chk(dram_dq_oe && dram_dq_out == exp_wdata, "R5 data", dram_dq_out, exp_wdata);
          mem[{cur_dev, cur_row, exp_col}] = dram_dq_out;
        end else begin
          chk(!dram_oe_n, "R4 oe", dram_oe_n, 0);
          rd_q <= mem.exists({cur_dev, cur_row, exp_col}) ? mem[{cur_dev, cur_row, exp_col}] : 8'hC3;
        end
      end
      hi_cnt = (&dram_ras_n) ? hi_cnt + 1 : 0;
      cas_lo_cnt = (!dram_cas_n) ? cas_lo_cnt + 1 : 0;
    end
    ras_prev <= dram_ras_n;
    cas_prev <= dram_cas_n;
    we_prev  <= dram_we_n;
    ma_prev  <= dram_ma;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drive(input bit wr, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_dev_oh = DEV_N'(1) << a[ADDR_W-1 -: 2];
    exp_row = a[COL_W +: ROW_W];
    exp_col = a[COL_W-1:0];
    exp_wdata = d;
  endtask

  task automatic wait_rsp(input int h, output logic [7:0] rd);
    int k = 0;
    while (!rsp_valid && k < 40) begin step(); k++; end
    chk(cyc == h + RSP_LAT, "R6 latency", cyc - h, RSP_LAT);
    rd = rsp_rdata;
    step();
    chk(!rsp_valid, "R6 pulse", rsp_valid, 0);
  endtask

  task automatic do_access(input bit wr, input logic [ADDR_W-1:0] a,
                           input logic [7:0] d, output logic [7:0] rd);
    int h;
    step();
    while (!req_ready) step();
    drive(wr, a, d);
    h = cyc + 1;
    step();
    req_valid = 1'b0;
    chk(!req_ready, "R11 busy", req_ready, 0);
    wait_rsp(h, rd);
  endtask

  task automatic wait_ref(output int t);
    int s = ref_cnt, k = 0;
    while (ref_cnt == s && k < 4 * P) begin step(); k++; end
    t = last_ref;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(dram_ras_n == '1 && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 7'h7F);
    rst_n = 1'b1;
    step();
    chk(req_ready && !rsp_valid && !dram_dq_oe, "R1 idle", {req_ready, rsp_valid, dram_dq_oe}, 3'b100);
    chk(dram_ras_n == '1 && dram_cas_n, "R1 strobes after", {dram_ras_n, dram_cas_n}, 5'h1F);
  endtask

  task automatic t_write_read();
    logic [ADDR_W-1:0] av [6];
    logic [7:0] dv [6];
    logic [7:0] rd;
    av[0] = {2'd0, 10'h000, 9'h000}; dv[0] = 8'hA5;
    av[1] = {2'd1, 10'h3FF, 9'h1FF}; dv[1] = 8'h3C;
    av[2] = {2'd2, 10'h155, 9'h0AA}; dv[2] = 8'hF0;
    av[3] = {2'd3, 10'h2AA, 9'h155}; dv[3] = 8'h0F;
    av[4] = {2'd3, 10'h005, 9'h007}; dv[4] = 8'h81;
    av[5] = {2'd1, 10'h005, 9'h007}; dv[5] = 8'h7E;
    for (int i = 0; i < 6; i++) do_access(1'b1, av[i], dv[i], rd);
    for (int i = 5; i >= 0; i--) begin
      do_access(1'b0, av[i], 8'h00, rd);
      chk(rd == dv[i], "R4 R2 readback", rd, dv[i]);
    end
  endtask

  task automatic t_refresh_idle();
    int t [4];
    for (int i = 0; i < 4; i++) wait_ref(t[i]);
    chk(t[2] - t[1] == P, "R8 interval a", t[2] - t[1], P);
    chk(t[3] - t[2] == P, "R8 interval b", t[3] - t[2], P);
  endtask

  task automatic t_back_to_back();
    int tr, h1, h2;
    logic [7:0] rd;
    wait_ref(tr);
    do_access(1'b1, {2'd2, 10'h011, 9'h022}, 8'h5B, rd);
    step();
    while (!req_ready) step();
    drive(1'b0, {2'd2, 10'h011, 9'h022}, 8'h00);
    h1 = cyc + 1;
    step();
    req_valid = 1'b0;
    while (cyc < h1 + FREE_LAT - 1) step();
    chk(!req_ready, "R11 low until precharge", req_ready, 0);
    drive(1'b0, {2'd0, 10'h011, 9'h022}, 8'h00);
    step();
    chk(req_ready, "R11 ready after precharge", req_ready, 1);
    h2 = cyc + 1;
    step();
    req_valid = 1'b0;
    chk(h2 == h1 + FREE_LAT + 1, "R11 second accept", h2 - h1, FREE_LAT + 1);
    wait_rsp(h2, rd);
    chk(rd == 8'hC3, "R2 other device empty", rd, 8'hC3);
  endtask

  task automatic t_refresh_collide();
    int t0, t1, h, h2, rc;
    logic [7:0] rd;
    wait_ref(t0);
    wait_ref(t1);
    h = t1 + P - 3 - CBR_LEAD;
    while (cyc < h - 1) step();
    drive(1'b1, {2'd1, 10'h0F0, 9'h00F}, 8'hE7);
    step();
    req_valid = 1'b0;
    rc = ref_cnt;
    while (cyc < h + RSP_LAT) step();
    chk(ref_cnt == rc, "R9 no refresh mid access", ref_cnt, rc);
    chk(rsp_valid, "R6 collide rsp", rsp_valid, 1);
    step();
    drive(1'b0, {2'd1, 10'h0F0, 9'h00F}, 8'h00);
    while (cyc < h + FREE_LAT) step();
    chk(!req_ready, "R9 ready low while due", req_ready, 0);
    while (ref_cnt == rc && cyc < h + 40) step();
    chk(last_ref == h + FREE_LAT + 1 + CBR_LEAD, "R9 refresh after precharge",
        last_ref - h, FREE_LAT + 1 + CBR_LEAD);
    h2 = h + FREE_LAT + 1 + CBR_LEAD + CBR_RAS + PRE_CYC + 1;
    while (!req_ready && cyc < h + 60) step();
    chk(cyc + 1 == h2, "R9 request after refresh", cyc + 1 - h, h2 - h);
    step();
    req_valid = 1'b0;
    wait_rsp(h2, rd);
    chk(rd == 8'hE7, "R9 R4 data", rd, 8'hE7);
    chk(last_acc > last_ref, "R9 order", last_acc, last_ref);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_refresh_idle();
    t_back_to_back();
    t_refresh_collide();
    repeat (5) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule